// File: doc/BRIEF.md
# Low-Register Immediate Arithmetic Execute Unit

This block executes one class of 16-bit compact instructions. Each instruction in the class names a single low register and an 8-bit constant, and asks for one of four operations: load the constant into the register, compare the register against the constant, add the constant, or subtract it. The caller supplies the instruction word, a bit that says whether the instruction sits inside a conditional-execution block, and the current value of the named register, which a register file outside this block reads combinationally. One clock after a valid strobe, the unit presents a registered result. That result carries a register write request (index and data), the four condition flags (negative, zero, carry, overflow) with separate update enables for the N/Z pair and the C/V pair, and a marker that says the word belongs to another class.

Flag behaviour depends on both the operation and the conditional-block bit. Compare exists only to set flags, so it sets them everywhere and never writes. Move touches only N and Z. Add and subtract keep the flags quiet while inside a conditional block.

Top module: `lri_exec`

## Requirements
- R1: A word whose bits [15:13] are not 3'b001 gives `foreign`=1 with `wr_en`, `upd_nz` and `upd_cv` all 0. A word in the class gives `foreign`=0.
- R2: For a word in the class, `wr_idx` equals bits [10:8] of the word. That register is also the source operand.
- R3: Operation code 2'b00 in bits [12:11] (move) writes the constant in bits [7:0], zero-extended to 32 bits, and sets `upd_cv`=0. It sets `upd_nz`=1 only outside a conditional block, with N=0 and Z=1 exactly when the constant is 0.
- R4: Operation code 2'b01 (compare) gives `wr_en`=0 and `upd_nz`=`upd_cv`=1, inside or outside a conditional block. The flags describe register minus the zero-extended constant.
- R5: Operation code 2'b10 (add) writes register plus constant, modulo 2^32. Outside a conditional block both enables are 1, with C = carry out of bit 31 and V = signed overflow. Inside a conditional block both enables are 0.
- R6: Operation code 2'b11 (subtract) writes register minus constant, modulo 2^32. Its flags follow the same conditional-block rule as add, with C=1 exactly when no borrow occurs (unsigned register >= constant) and V = signed overflow. N is bit 31 of the result and Z is 1 when the result is zero. The same N, Z, C and V rules apply to compare.
- R7: Outputs appear on the clock edge that samples `in_valid`=1, together with a one-cycle `out_valid` pulse. After an edge that samples `in_valid`=0, `out_valid`, `wr_en`, `upd_nz`, `upd_cv` and `foreign` are all 0.
- R8: While `rst` is high at a clock edge, `out_valid`, `wr_en`, `upd_nz`, `upd_cv` and `foreign` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operand are valid this cycle |
| instr | input | 16 | Instruction word |
| in_cond | input | 1 | Instruction lies inside a conditional-execution block |
| reg_val | input | 32 | Current value of the register named by bits [10:8] |
| out_valid | output | 1 | One-cycle pulse marking registered results |
| wr_en | output | 1 | Register write request |
| wr_idx | output | 3 | Destination register index |
| wr_data | output | 32 | Value to write |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |
| flag_v | output | 1 | Overflow flag value |
| upd_nz | output | 1 | Apply flag_n and flag_z |
| upd_cv | output | 1 | Apply flag_c and flag_v |
| foreign | output | 1 | Word is not of this instruction class |

## Verification
The embedded assertions check, on every cycle, the rules that need only past inputs: a foreign word raises no enable, compare never writes and always updates flags, move never updates C/V and never reports a negative result, the index follows the word, the valid pulse follows the strobe, and the subtract carry matches an unsigned compare. Only the bench scenarios show the arithmetic itself: wrap-around sums, signed overflow at both ends of the range, the zero result, and how the conditional-block bit changes each operation. The bench also covers back-to-back strobes and a reset that arrives while a result is pending.

// File: rtl/lri_pkg.sv
package lri_pkg;

    typedef enum logic [1:0] {
        OP_MOV = 2'b00,
        OP_CMP = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } lri_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } lri_flags_t;

    typedef struct packed {
        logic wr;
        logic upd_nz;
        logic upd_cv;
    } lri_ctl_t;

    localparam logic [2:0] LRI_CLASS_CODE = 3'b001;

    // Write and flag-enable policy for one operation.
    function automatic lri_ctl_t lri_policy(input lri_op_e op, input logic in_cond);
        lri_ctl_t c;
        unique case (op)
            OP_MOV: c = '{wr: 1'b1, upd_nz: !in_cond, upd_cv: 1'b0};
            OP_CMP: c = '{wr: 1'b0, upd_nz: 1'b1,     upd_cv: 1'b1};
            default: c = '{wr: 1'b1, upd_nz: !in_cond, upd_cv: !in_cond};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lri_decode.sv
module lri_decode
    import lri_pkg::*;
#(
    parameter int IW    = 16,
    parameter int IMM_W = 8,
    parameter int IDX_W = 3
) (
    input  logic [IW-1:0]    word,
    output logic             mine,
    output lri_op_e          op,
    output logic [IDX_W-1:0] idx,
    output logic [IMM_W-1:0] imm
);
    localparam int IDX_LSB = IMM_W;
    localparam int OP_LSB  = IDX_LSB + IDX_W;
    localparam int CLS_LSB = OP_LSB + 2;
    localparam int CLS_W   = IW - CLS_LSB;

    always_comb begin
        mine = (word[IW-1:CLS_LSB] == CLS_W'(LRI_CLASS_CODE));
        op   = lri_op_e'(word[OP_LSB +: 2]);
        idx  = word[IDX_LSB +: IDX_W];
        imm  = word[IMM_W-1:0];
    end
endmodule

// File: rtl/lri_alu.sv
module lri_alu
    import lri_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  lri_op_e           op,
    input  logic [DATA_W-1:0] opnd,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output lri_flags_t        flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   dif_w;
    logic              add_ovf;
    logic              sub_ovf;

    always_comb begin
        imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm};
        sum_w   = {1'b0, opnd} + {1'b0, imm_ext};
        dif_w   = {1'b0, opnd} - {1'b0, imm_ext};
        add_ovf = (opnd[MSB] == imm_ext[MSB]) && (sum_w[MSB] != opnd[MSB]);
        sub_ovf = (opnd[MSB] != imm_ext[MSB]) && (dif_w[MSB] != opnd[MSB]);

        unique case (op)
            OP_MOV: begin
                result  = imm_ext;
                flags.c = 1'b0;
                flags.v = 1'b0;
            end
            OP_ADD: begin
                result  = sum_w[DATA_W-1:0];
                flags.c = sum_w[DATA_W];
                flags.v = add_ovf;
            end
            default: begin
                result  = dif_w[DATA_W-1:0];
                flags.c = !dif_w[DATA_W];
                flags.v = sub_ovf;
            end
        endcase
        flags.n = result[MSB];
        flags.z = (result == '0);
    end
endmodule

// File: rtl/lri_exec.sv
module lri_exec
    import lri_pkg::*;
#(
    parameter int IW     = 16,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IW-1:0]     instr,
    input  logic              in_cond,
    input  logic [DATA_W-1:0] reg_val,
    output logic              out_valid,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              upd_nz,
    output logic              upd_cv,
    output logic              foreign
);
    logic             d_mine;
    lri_op_e          d_op;
    logic [IDX_W-1:0] d_idx;
    logic [IMM_W-1:0] d_imm;
    logic [DATA_W-1:0] a_res;
    lri_flags_t       a_flags;
    lri_ctl_t         ctl;
    lri_flags_t       flags_q;

    lri_decode #(.IW(IW), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_dec (
        .word (instr),
        .mine (d_mine),
        .op   (d_op),
        .idx  (d_idx),
        .imm  (d_imm)
    );

    lri_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_alu (
        .op     (d_op),
        .opnd   (reg_val),
        .imm    (d_imm),
        .result (a_res),
        .flags  (a_flags)
    );

    always_comb begin
        ctl = d_mine ? lri_policy(d_op, in_cond) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            upd_nz    <= 1'b0;
            upd_cv    <= 1'b0;
            foreign   <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
            flags_q   <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && ctl.wr;
            upd_nz    <= in_valid && ctl.upd_nz;
            upd_cv    <= in_valid && ctl.upd_cv;
            foreign   <= in_valid && !d_mine;
            if (in_valid) begin
                wr_idx  <= d_idx;
                wr_data <= d_mine ? a_res : '0;
                flags_q <= a_flags;
            end
        end
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

    // Assertions
    localparam int CLS_LSB = IMM_W + IDX_W + 2;

    assert_foreign_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        foreign |-> (!wr_en && !upd_nz && !upd_cv && out_valid));

    assert_index_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !foreign) |-> (wr_idx == $past(instr[IMM_W +: IDX_W])));

    assert_move_nz_only_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[IW-1:IMM_W+IDX_W] == {LRI_CLASS_CODE, OP_MOV})
        |=> (!upd_cv && wr_en && !flag_n));

    assert_compare_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[IW-1:IMM_W+IDX_W] == {LRI_CLASS_CODE, OP_CMP})
        |=> (!wr_en && upd_nz && upd_cv));

    assert_sub_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[IW-1:CLS_LSB] == LRI_CLASS_CODE && instr[IMM_W+IDX_W] == 1'b1
         && instr[IMM_W+IDX_W+1] == 1'b1 && !in_cond)
        |=> (flag_c == ($past(reg_val) >= DATA_W'($past(instr[IMM_W-1:0])))));

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en && !upd_nz && !upd_cv && !foreign));

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

endmodule

// File: tb/sim_lri_exec.sv
module sim_lri_exec;

    typedef struct packed {
        logic [15:0] ins;
        logic        cond;
        logic [31:0] rs;
        logic        we;
        logic [31:0] data;
        logic [3:0]  nzcv;
        logic        unz;
        logic        ucv;
        logic        nm;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{16'h2300, 1'b0, 32'h0000_1234, 1'b1, 32'h0000_0000, 4'b0100, 1'b1, 1'b0, 1'b0},
        '{16'h2580, 1'b1, 32'h0000_0000, 1'b1, 32'h0000_0080, 4'b0000, 1'b0, 1'b0, 1'b0},
        '{16'h2905, 1'b0, 32'h0000_0005, 1'b0, 32'h0000_0000, 4'b0110, 1'b1, 1'b1, 1'b0},
        '{16'h2A10, 1'b1, 32'h0000_0003, 1'b0, 32'h0000_0000, 4'b1000, 1'b1, 1'b1, 1'b0},
        '{16'h2801, 1'b0, 32'h8000_0000, 1'b0, 32'h0000_0000, 4'b0011, 1'b1, 1'b1, 1'b0},
        '{16'h3401, 1'b0, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 4'b0110, 1'b1, 1'b1, 1'b0},
        '{16'h37FF, 1'b0, 32'h7FFF_FFFF, 1'b1, 32'h8000_00FE, 4'b1001, 1'b1, 1'b1, 1'b0},
        '{16'h3602, 1'b1, 32'h0000_000A, 1'b1, 32'h0000_000C, 4'b0000, 1'b0, 1'b0, 1'b0},
        '{16'h3B20, 1'b0, 32'h0000_0010, 1'b1, 32'hFFFF_FFF0, 4'b1000, 1'b1, 1'b1, 1'b0},
        '{16'h3801, 1'b0, 32'h8000_0000, 1'b1, 32'h7FFF_FFFF, 4'b0011, 1'b1, 1'b1, 1'b0},
        '{16'h3900, 1'b1, 32'h0000_0000, 1'b1, 32'h0000_0000, 4'b0000, 1'b0, 1'b0, 1'b0},
        '{16'h3A7F, 1'b0, 32'h0000_007F, 1'b1, 32'h0000_0000, 4'b0110, 1'b1, 1'b1, 1'b0},
        '{16'h4000, 1'b0, 32'h0000_0001, 1'b0, 32'h0000_0000, 4'b0000, 1'b0, 1'b0, 1'b1},
        '{16'h1C05, 1'b0, 32'h0000_0001, 1'b0, 32'h0000_0000, 4'b0000, 1'b0, 1'b0, 1'b1},
        '{16'hE123, 1'b1, 32'h0000_0001, 1'b0, 32'h0000_0000, 4'b0000, 1'b0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        in_cond = 1'b0;
    logic [31:0] reg_val = '0;
    logic        out_valid, wr_en, flag_n, flag_z, flag_c, flag_v, upd_nz, upd_cv, foreign;
    logic [2:0]  wr_idx;
    logic [31:0] wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    lri_exec u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .in_cond(in_cond),
        .reg_val(reg_val), .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .flag_v(flag_v), .upd_nz(upd_nz), .upd_cv(upd_cv), .foreign(foreign)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [15:0] w);
        if (w[15:13] != 3'b001) return "R1";
        case (w[12:11])
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic issue(input logic [15:0] w, input logic c, input logic [31:0] r);
        @(negedge clk);
        instr    = w;
        in_cond  = c;
        reg_val  = r;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_quiet(input string req);
        check(req, "out_valid", 32'(out_valid), 32'd0);
        check(req, "enables", {29'd0, wr_en, upd_nz, upd_cv}, 32'd0);
        check(req, "foreign", 32'(foreign), 32'd0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check_quiet("R8");
        rst = 1'b0;

        // Table walk: R1..R6
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = req_of(VEC[i].ins);
            issue(VEC[i].ins, VEC[i].cond, VEC[i].rs);
            check("R7", "out_valid", 32'(out_valid), 32'd1);
            check(rq, "foreign", 32'(foreign), 32'(VEC[i].nm));
            check(rq, "wr_en", 32'(wr_en), 32'(VEC[i].we));
            check(rq, "upd_nz", 32'(upd_nz), 32'(VEC[i].unz));
            check(rq, "upd_cv", 32'(upd_cv), 32'(VEC[i].ucv));
            if (!VEC[i].nm) check("R2", "wr_idx", 32'(wr_idx), 32'(VEC[i].ins[10:8]));
            if (VEC[i].we) check(rq, "wr_data", wr_data, VEC[i].data);
            if (VEC[i].unz) check(rq, "nz", {30'd0, flag_n, flag_z}, {30'd0, VEC[i].nzcv[3:2]});
            if (VEC[i].ucv) check(rq, "cv", {30'd0, flag_c, flag_v}, {30'd0, VEC[i].nzcv[1:0]});
            // R7: the pulse lasts one cycle
            @(negedge clk);
            check_quiet("R7");
        end

        // R7: back-to-back strobes, each result one cycle after its strobe
        @(negedge clk);
        instr = 16'h3405; in_cond = 1'b0; reg_val = 32'd100; in_valid = 1'b1;
        @(negedge clk);
        check("R7", "b2b first data", wr_data, 32'd105);
        check("R7", "b2b first valid", 32'(out_valid), 32'd1);
        instr = 16'h3203; reg_val = 32'd7;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7", "b2b second data", wr_data, 32'd10);
        check("R2", "b2b second idx", 32'(wr_idx), 32'd2);
        @(negedge clk);
        check_quiet("R7");

        // R8: reset that arrives while a result is pending
        instr = 16'h2905; reg_val = 32'd5; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_quiet("R8");
        rst = 1'b0;
        @(negedge clk);
        check_quiet("R8");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule